// File: doc/BRIEF.md
# Square-Wave Interval Timer

This block is a programmable down counter clocked by the rising edges of an external timer input. That input is first passed through a synchronizer into the system clock domain. Software writes a 16-bit count-length register one byte at a time. The upper two bits choose the output behaviour and the lower fourteen bits give the period length in input periods. A separate command input starts, stops or arms a stop at the end of the current period.

The counter works in two halves of each period and steps by two in each half. Its value therefore never equals the raw number of input edges. For an odd length the extra input period goes to the high half. The output is either a square wave or a one-period low pulse at the end of the period. Either form can run once or repeat by reloading itself. A START issued while the timer runs is held and takes effect at the next terminal count. A sticky flag records each terminal count until status is read. Reset stops the timer but keeps the stored count and mode.

Top module: `sqw_timer`

## Requirements
- R1: Reset clears running, the flag and any pending command, and drives tmr_out high. The count-length register, the active mode and the counter value are kept, so cnt_rd is unchanged by reset.
- R2: With wr_en high, wr_lane 0 writes wr_data into register bits 7:0 and wr_lane 1 writes bits 15:8. Bits 13:0 are the length N. Bit 15 selects pulse output (0 = square), and bit 14 selects reload (0 = one-shot). cmd codes are 00 no-op, 01 stop, 10 stop at terminal count, 11 start.
- R3: START while idle loads the mode and length and sets running in the next cycle. Lengths 0 and 1 are treated as 2.
- R4: In square modes tmr_out is high for ceil(N/2) rising input edges and low for floor(N/2). Terminal count falls on the N-th edge.
- R5: In pulse modes tmr_out is high except during the last input period before terminal count, when it is low.
- R6: At terminal count a one-shot mode stops and tmr_out returns high. A reload mode restarts the same length and stays running.
- R7: cnt_rd gives the active mode in bits 15:14 and the counter in bits 13:0. The counter value is 2*(edges left in the current half) - 2.
- R8: START while running stores the register contents without changing the active mode or count. The stored values are loaded at the next terminal count.
- R9: STOP halts a running timer in the next cycle. STOP-at-TC halts it at its next terminal count. Both have no effect while idle.
- R10: tc_flag is set at each terminal count and cleared by stat_rd. If both happen in the same cycle, the set wins.
- R11: A cycle with a non-no-op command ignores any input edge that arrives in that same cycle.
- R12: tmr_in is synchronised. Only a low-to-high transition counts, however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_in | input | 1 | Asynchronous timer input |
| wr_en | input | 1 | Byte write strobe for the count-length register |
| wr_lane | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Write data |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 2 | Command code |
| stat_rd | input | 1 | Status read, clears tc_flag |
| tmr_out | output | 1 | Square wave or pulse output |
| tc_flag | output | 1 | Sticky terminal-count flag |
| running | output | 1 | Timer is counting |
| cnt_rd | output | 16 | Active mode and current counter value |

## Verification
The embedded assertions guard, on every cycle, several invariants. The counter stays even while running. STOP always takes effect. A deferred START leaves the active mode untouched. A one-shot terminal count ends the run. A command cycle freezes the counter. Terminal count always raises the flag, and a status read clears it. The exact high and low split of odd lengths, the placement of the pulse and the hand-over from a deferred START at terminal count can only be seen in the bench's scenarios. The same is true of register contents surviving reset and of edge masking under a command. In those scenarios a behavioural model tracks the remaining edges per half and is compared with the outputs on every clock.

// File: rtl/sqw_timer_pkg.sv
package sqw_timer_pkg;
   typedef enum logic [1:0] {
      CMD_NOP     = 2'b00,
      CMD_STOP    = 2'b01,
      CMD_STOP_TC = 2'b10,
      CMD_START   = 2'b11
   } tmr_cmd_e;

   // positions inside the two-bit mode field
   localparam int MODE_RELOAD_BIT = 0;
   localparam int MODE_PULSE_BIT  = 1;
   localparam int MODE_W          = 2;
endpackage

// File: rtl/sqw_tin_sync.sv
module sqw_tin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic tin,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sqw_tin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr_q;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) sr_q[0] <= 1'b0;
            else     sr_q[0] <= tin;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) sr_q[i] <= 1'b0;
            else     sr_q[i] <= sr_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= sr_q[STAGES-1];
   end

   assign rise = sr_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sqw_len_reg.sv
module sqw_len_reg #(
   parameter int CNT_W  = 14,
   parameter int LANE_W = 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [LANE_W-1:0] wr_lane,
   input  logic [7:0]        wr_data,
   output logic [CNT_W+1:0]  clr
);
   localparam int CLR_W = CNT_W + 2;

   // one flop per bit; the lane that owns it follows from its position
   for (genvar b = 0; b < CLR_W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_lane == LANE_W'(b / 8)))
            bit_q <= wr_data[b % 8];
      end
      assign clr[b] = bit_q;
   end
endmodule

// File: rtl/sqw_count_core.sv
module sqw_count_core
   import sqw_timer_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rise,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd,
   input  logic [CNT_W+1:0] clr,
   input  logic             stat_rd,
   output logic             tout,
   output logic             tc_flag,
   output logic             running,
   output logic [CNT_W+1:0] cnt_rd
);
   typedef logic [CNT_W-1:0] cnt_t;

   function automatic cnt_t fix_len(cnt_t n);
      return (n < cnt_t'(2)) ? cnt_t'(2) : n;
   endfunction

   // 2*ceil(n/2) - 2, computed one bit wider to avoid wrap at full scale
   function automatic cnt_t hi_init(cnt_t n);
      logic [CNT_W:0] w;
      w = {1'b0, n} + (CNT_W+1)'(n[0]) - (CNT_W+1)'(2);
      return w[CNT_W-1:0];
   endfunction

   // 2*floor(n/2) - 2
   function automatic cnt_t lo_init(cnt_t n);
      logic [CNT_W:0] w;
      w = {1'b0, n} - (CNT_W+1)'(n[0]) - (CNT_W+1)'(2);
      return w[CNT_W-1:0];
   endfunction

   tmr_cmd_e          cmd_e;
   logic              cmd_act;
   logic              tc_evt;
   logic              run_q, ph_q, pst_q, pstp_q, flag_q;
   cnt_t              cnt_q, alen_q, nlen_q;
   logic [MODE_W-1:0] amode_q, nmode_q;
   cnt_t              clr_len;
   logic [MODE_W-1:0] clr_mode;

   assign cmd_e    = tmr_cmd_e'(cmd);
   assign cmd_act  = cmd_valid && (cmd_e != CMD_NOP);
   assign clr_len  = fix_len(clr[CNT_W-1:0]);
   assign clr_mode = clr[CNT_W+1:CNT_W];
   assign tc_evt   = run_q && rise && !cmd_act && ph_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= 1'b0;
         pst_q  <= 1'b0;
         pstp_q <= 1'b0;
      end else if (cmd_act) begin
         unique case (cmd_e)
            CMD_START: begin
               if (!run_q) begin
                  run_q   <= 1'b1;
                  pst_q   <= 1'b0;
                  pstp_q  <= 1'b0;
                  amode_q <= clr_mode;
                  alen_q  <= clr_len;
                  ph_q    <= 1'b0;
                  cnt_q   <= hi_init(clr_len);
               end else begin
                  pst_q   <= 1'b1;
                  nlen_q  <= clr_len;
                  nmode_q <= clr_mode;
               end
            end
            CMD_STOP: begin
               if (run_q) begin
                  run_q  <= 1'b0;
                  pst_q  <= 1'b0;
                  pstp_q <= 1'b0;
               end
            end
            CMD_STOP_TC: begin
               if (run_q) pstp_q <= 1'b1;
            end
            default: ;
         endcase
      end else if (run_q && rise) begin
         if (!ph_q) begin
            if (cnt_q == '0) begin
               ph_q  <= 1'b1;
               cnt_q <= lo_init(alen_q);
            end else begin
               cnt_q <= cnt_q - cnt_t'(2);
            end
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - cnt_t'(2);
         end else begin
            pst_q  <= 1'b0;
            pstp_q <= 1'b0;
            if (pst_q) begin
               amode_q <= nmode_q;
               alen_q  <= nlen_q;
               ph_q    <= 1'b0;
               cnt_q   <= hi_init(nlen_q);
            end else if (pstp_q || !amode_q[MODE_RELOAD_BIT]) begin
               run_q <= 1'b0;
            end else begin
               ph_q  <= 1'b0;
               cnt_q <= hi_init(alen_q);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)          flag_q <= 1'b0;
      else if (tc_evt)  flag_q <= 1'b1;
      else if (stat_rd) flag_q <= 1'b0;
   end

   logic last_period;
   assign last_period = ph_q && (cnt_q == '0);

   always_comb begin
      if (!run_q)                        tout = 1'b1;
      else if (amode_q[MODE_PULSE_BIT])  tout = ~last_period;
      else                               tout = ~ph_q;
   end

   assign tc_flag = flag_q;
   assign running = run_q;
   assign cnt_rd  = {amode_q, cnt_q};

   // R7
   cnt_even_chk: assert property (@(posedge clk) disable iff (rst)
      run_q |-> !cnt_q[0]);
   // R9
   stop_now_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_e == CMD_STOP) |=> !run_q);
   // R8
   defer_start_chk: assert property (@(posedge clk) disable iff (rst)
      (run_q && cmd_valid && cmd_e == CMD_START) |=> (run_q && $stable(amode_q) && $stable(cnt_q)));
   // R11
   cmd_masks_edge_chk: assert property (@(posedge clk) disable iff (rst)
      (run_q && cmd_valid && cmd_e == CMD_STOP_TC) |=> ($stable(cnt_q) && $stable(ph_q)));
   // R6
   oneshot_end_chk: assert property (@(posedge clk) disable iff (rst)
      (tc_evt && !pst_q && !amode_q[MODE_RELOAD_BIT]) |=> !run_q);
   // R10
   tc_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
      tc_evt |=> tc_flag);
   // R10
   rd_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_rd && !tc_evt) |=> !tc_flag);
endmodule

// File: rtl/sqw_timer.sv
module sqw_timer #(
   parameter int CNT_W       = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tmr_in,
   input  logic             wr_en,
   input  logic             wr_lane,
   input  logic [7:0]       wr_data,
   input  logic             cmd_valid,
   input  logic [1:0]       cmd,
   input  logic             stat_rd,
   output logic             tmr_out,
   output logic             tc_flag,
   output logic             running,
   output logic [CNT_W+1:0] cnt_rd
);
   localparam int CLR_W = CNT_W + 2;
   localparam int LANES = (CLR_W + 7) / 8;

   if (CNT_W < 7 || CNT_W > 14) begin : g_bad_width
      $error("sqw_timer: CNT_W must lie in 7..14 for a two-byte register");
   end
   if (LANES != 2) begin : g_bad_lanes
      $error("sqw_timer: register must span exactly two byte lanes");
   end

   logic             rise;
   logic [CLR_W-1:0] clr;

   sqw_tin_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk (clk),
      .rst (rst),
      .tin (tmr_in),
      .rise(rise)
   );

   sqw_len_reg #(.CNT_W(CNT_W), .LANE_W(1)) len_i (
      .clk    (clk),
      .wr_en  (wr_en),
      .wr_lane(wr_lane),
      .wr_data(wr_data),
      .clr    (clr)
   );

   sqw_count_core #(.CNT_W(CNT_W)) core_i (
      .clk      (clk),
      .rst      (rst),
      .rise     (rise),
      .cmd_valid(cmd_valid),
      .cmd      (cmd),
      .clr      (clr),
      .stat_rd  (stat_rd),
      .tout     (tmr_out),
      .tc_flag  (tc_flag),
      .running  (running),
      .cnt_rd   (cnt_rd)
   );
endmodule

// File: tb/sqw_timer_tb_top.sv
`timescale 1ns/1ps
module sqw_timer_tb_top;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tmr_in = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_lane = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd = 2'b00;
   logic        stat_rd = 1'b0;
   logic        tmr_out, tc_flag, running;
   logic [15:0] cnt_rd;

   int n_chk = 0;
   int n_err = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sqw_timer dut_i (
      .clk(clk), .rst(rst), .tmr_in(tmr_in), .wr_en(wr_en), .wr_lane(wr_lane),
      .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd(cmd), .stat_rd(stat_rd),
      .tmr_out(tmr_out), .tc_flag(tc_flag), .running(running), .cnt_rd(cnt_rd)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference: remaining edges per half, not a counter copy
   bit [15:0] m_clr;
   bit m_run, m_ph, m_pst, m_pstp, m_flag, m_known;
   int m_rem, m_alen, m_nlen;
   bit [1:0] m_mode, m_nmode;
   bit m_sh [SYNC];
   bit m_dly;

   task automatic m_load(input int n, input bit [1:0] md);
      if (n < 2) n = 2;
      m_alen = n; m_mode = md; m_ph = 0; m_rem = (n + 1) / 2;
      m_run = 1; m_known = 1; m_pst = 0; m_pstp = 0;
   endtask

   always @(posedge clk) begin
      bit r, tc, act;
      r = 0; tc = 0;
      if (rst) begin
         m_run = 0; m_pst = 0; m_pstp = 0; m_flag = 0; m_dly = 0;
         for (int i = 0; i < SYNC; i++) m_sh[i] = 0;
      end else begin
         r = m_sh[SYNC-1] && !m_dly;
         m_dly = m_sh[SYNC-1];
         for (int i = SYNC - 1; i > 0; i--) m_sh[i] = m_sh[i-1];
         m_sh[0] = tmr_in;
         act = cmd_valid && (cmd != 2'b00);
         if (act) begin
            case (cmd)
               2'b11: if (!m_run) m_load(int'(m_clr[13:0]), m_clr[15:14]);
                      else begin
                         m_pst = 1; m_nlen = int'(m_clr[13:0]); m_nmode = m_clr[15:14];
                         if (m_nlen < 2) m_nlen = 2;
                      end
               2'b01: if (m_run) begin m_run = 0; m_pst = 0; m_pstp = 0; end
               2'b10: if (m_run) m_pstp = 1;
               default: ;
            endcase
         end else if (m_run && r) begin
            if (m_rem > 1) m_rem--;
            else if (!m_ph) begin m_ph = 1; m_rem = m_alen / 2; end
            else begin
               tc = 1;
               if (m_pst) m_load(m_nlen, m_nmode);
               else if (m_pstp || !m_mode[0]) begin m_run = 0; m_pstp = 0; end
               else begin m_ph = 0; m_rem = (m_alen + 1) / 2; end
            end
         end
         if (tc) m_flag = 1;
         else if (stat_rd) m_flag = 0;
      end
      if (wr_en) begin
         if (wr_lane) m_clr[15:8] = wr_data;
         else         m_clr[7:0]  = wr_data;
      end
   end

   always @(negedge clk) begin
      if (chk_on) begin
         bit exp_out;
         if (!m_run) exp_out = 1;
         else if (m_mode[1]) exp_out = !(m_ph && m_rem == 1);
         else exp_out = !m_ph;
         check(tmr_out == exp_out, "R4 R5 R6 model tmr_out", tmr_out, exp_out);
         check(tc_flag == m_flag, "R10 model tc_flag", tc_flag, m_flag);
         check(running == m_run, "R9 model running", running, m_run);
         if (m_known)
            check(cnt_rd == {m_mode, 14'(2 * m_rem - 2)}, "R7 model cnt_rd",
                  cnt_rd, {m_mode, 14'(2 * m_rem - 2)});
      end
   end

   task automatic wr(input bit lane, input bit [7:0] d);
      @(negedge clk); wr_en = 1; wr_lane = lane; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask
   task automatic issue(input bit [1:0] c);
      @(negedge clk); cmd_valid = 1; cmd = c;
      @(negedge clk); cmd_valid = 0; cmd = 2'b00;
   endtask
   task automatic rd_stat();
      @(negedge clk); stat_rd = 1;
      @(negedge clk); stat_rd = 0;
   endtask
   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tmr_in = 1;
         repeat (2) @(negedge clk);
         tmr_in = 0;
         repeat (3) @(negedge clk);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      chk_on = 1;
      @(negedge clk);
      check(running == 0 && tc_flag == 0 && tmr_out == 1, "R1 reset state",
            {running, tc_flag, tmr_out}, 3'b001);

      // square, reload, odd length 9
      wr(0, 8'd9); wr(1, 8'h40); issue(2'b11);
      check(cnt_rd == 16'h4008, "R2 R3 start readback", cnt_rd, 16'h4008);
      pulses(4);
      check(tmr_out == 1, "R4 high half of 9", tmr_out, 1);
      pulses(1);
      check(tmr_out == 0 && cnt_rd == 16'h4006, "R4 low half of 9", cnt_rd, 16'h4006);
      pulses(4);
      check(tc_flag == 1 && running == 1 && tmr_out == 1, "R6 R10 reload at TC",
            {tc_flag, running, tmr_out}, 3'b111);
      rd_stat();
      check(tc_flag == 0, "R10 status read clears", tc_flag, 0);
      issue(2'b01);
      check(running == 0 && tmr_out == 1, "R9 stop immediate", {running, tmr_out}, 2'b01);

      // pulse one-shot, length 4
      wr(0, 8'd4); wr(1, 8'h80); issue(2'b11);
      pulses(3);
      check(tmr_out == 0 && running == 1, "R5 pulse in last period", tmr_out, 0);
      pulses(1);
      check(running == 0 && tmr_out == 1 && tc_flag == 1, "R6 one-shot ends",
            {running, tmr_out, tc_flag}, 3'b011);
      rd_stat();

      // deferred start
      wr(0, 8'd6); wr(1, 8'hC0); issue(2'b11);
      pulses(1);
      wr(0, 8'd3); wr(1, 8'h00); issue(2'b11);
      check(cnt_rd[15:14] == 2'b11 && running == 1, "R8 start held while running",
            cnt_rd, 16'hC000);
      pulses(5);
      check(cnt_rd == 16'h0002 && running == 1, "R8 new values at TC", cnt_rd, 16'h0002);
      pulses(3);
      check(running == 0, "R6 deferred one-shot ends", running, 0);
      rd_stat();

      // stop at TC, then idle stop
      wr(0, 8'd4); wr(1, 8'h40); issue(2'b11); issue(2'b10);
      pulses(3);
      check(running == 1, "R9 still running before TC", running, 1);
      pulses(1);
      check(running == 0 && tc_flag == 1, "R9 stop at TC", {running, tc_flag}, 2'b01);
      issue(2'b01); issue(2'b10);
      check(running == 0 && tc_flag == 1 && tmr_out == 1, "R9 idle commands ignored",
            {running, tc_flag, tmr_out}, 3'b011);
      rd_stat();

      // long high input counts once
      wr(0, 8'd10); wr(1, 8'h40); issue(2'b11);
      @(negedge clk); tmr_in = 1;
      repeat (10) @(negedge clk);
      tmr_in = 0;
      repeat (4) @(negedge clk);
      check(cnt_rd == 16'h4006, "R12 one count per rising edge", cnt_rd, 16'h4006);
      pulses(1);
      check(cnt_rd == 16'h4004, "R7 counter steps by two", cnt_rd, 16'h4004);

      // reset keeps contents
      @(negedge clk); rst = 1;
      repeat (2) @(negedge clk);
      rst = 0;
      @(negedge clk);
      check(running == 0 && tc_flag == 0 && tmr_out == 1 && cnt_rd == 16'h4004,
            "R1 reset keeps count", cnt_rd, 16'h4004);

      // command masks a coincident edge
      issue(2'b11);
      @(negedge clk); tmr_in = 1; cmd_valid = 1; cmd = 2'b10;
      repeat (4) @(negedge clk);
      cmd_valid = 0; cmd = 2'b00; tmr_in = 0;
      repeat (3) @(negedge clk);
      check(cnt_rd == 16'h4008 && running == 1, "R11 edge masked by command",
            cnt_rd, 16'h4008);
      issue(2'b01);

      // length below two
      wr(0, 8'd1); wr(1, 8'h00); issue(2'b11);
      check(cnt_rd == 16'h0000 && running == 1, "R3 length 1 as 2", cnt_rd, 16'h0000);
      pulses(2);
      check(running == 0 && tc_flag == 1, "R3 two edges to TC", {running, tc_flag}, 2'b01);

      repeat (4) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule